// File: doc/BRIEF.md
# Coherence Home Directory Controller

This block sits at the home node of a linked-list coherence scheme and holds a small tag for every memory line. Each tag has a 2-bit memory state and the identifier of the node at the head of that line's sharing list. The directory does not record the other sharers. Each new requester learns the identity of the previous head from the directory and then contacts that node itself.

Nodes send fetch requests, either with read privilege or with read/write privilege. Each request names the requester and the line. A request queue with a ready/valid handshake collects them. The controller takes the oldest queued request, reads the line's tag and answers. The answer carries data, or the identifier of the previous head, or both. The controller then writes back the new state, with the requester recorded as the new head. Only one request is in service at a time. The next one is taken only after the previous answer has been issued, so every line sees its requests in arrival order.

Top module: `coh_home_dir`

## Requirements
- R1: After reset every line is in the unshared state, `req_ready` is high and `rsp_valid` is low.
- R2: The state field uses 2'b00 for unshared, 2'b01 for clean-shared (the list copy matches memory) and 2'b10 for dirty-away (the list copy may differ from memory). The encoding 2'b11 is reserved, is read as unshared, and never appears on `rsp_state`.
- R3: A read fetch (`req_wr`=0) to an unshared line answers with `rsp_data`=1 and `rsp_head_vld`=0, and leaves the line clean-shared.
- R4: A read/write fetch (`req_wr`=1) to an unshared or clean-shared line answers with `rsp_data`=1 and leaves the line dirty-away.
- R5: A fetch to a line that already has a sharing list (clean-shared or dirty-away) answers with `rsp_head_vld`=1 and `rsp_head` equal to the head identifier stored before the request.
- R6: A fetch of either kind to a dirty-away line answers with `rsp_data`=0, and the line stays dirty-away.
- R7: Every serviced fetch overwrites the line's head identifier with the requester's `req_node`.
- R8: The request queue holds 4 entries. While it is full `req_ready` is low, and a request presented then is not taken.
- R9: Requests are answered one at a time, in the order they were accepted. Two answers never come in consecutive cycles. When the controller is idle, the answer appears in the second cycle after the accepting edge.
- R10: A read fetch to a clean-shared line answers with `rsp_data`=1, and the line stays clean-shared.
- R11: Each line's tag is independent. A fetch changes only the tag of the line it names.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Queue can accept a request |
| req_wr | input | 1 | 1 = read/write fetch, 0 = read fetch |
| req_node | input | NODE_W | Requester identifier |
| req_line | input | LINE_W | Line index |
| rsp_valid | output | 1 | Answer strobe, one cycle |
| rsp_node | output | NODE_W | Requester being answered |
| rsp_line | output | LINE_W | Line being answered |
| rsp_data | output | 1 | Memory data is supplied with this answer |
| rsp_head_vld | output | 1 | `rsp_head` carries the previous head |
| rsp_head | output | NODE_W | Previous head identifier |
| rsp_state | output | 2 | Line state after this fetch |

## Verification
The assertions check several rules on every cycle. Answers never come back to back, and no answer appears while a request is in service. Queue occupancy never exceeds its depth. A read/write fetch always ends dirty-away, an answer without data is always a dirty-away hand-off with a head, and the reserved state is never reported. Only the bench's scenarios can show the actual state sequence for a line, namely which head identifier is handed to each requester. The same holds for per-line independence and for the fill of the queue under a back-to-back burst. The bench also checks that a burst comes out complete and in arrival order.

// File: rtl/coh_home_dir.sv
module coh_home_dir #(
  parameter int NODE_W = 4,
  parameter int LINE_W = 3,
  parameter int QDEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_wr,
  input  logic [NODE_W-1:0] req_node,
  input  logic [LINE_W-1:0] req_line,
  output logic              rsp_valid,
  output logic [NODE_W-1:0] rsp_node,
  output logic [LINE_W-1:0] rsp_line,
  output logic              rsp_data,
  output logic              rsp_head_vld,
  output logic [NODE_W-1:0] rsp_head,
  output logic [1:0]        rsp_state
);
  localparam int LINES = 1 << LINE_W;
  localparam int QW    = $clog2(QDEPTH);
  localparam int CW    = $clog2(QDEPTH + 1);
  localparam logic [1:0] ST_HOME  = 2'b00;
  localparam logic [1:0] ST_FRESH = 2'b01;
  localparam logic [1:0] ST_GONE  = 2'b10;

  typedef struct packed {
    logic              wr;
    logic [NODE_W-1:0] node;
    logic [LINE_W-1:0] line;
  } req_t;

  req_t              q_mem [QDEPTH];
  logic [QW-1:0]     wp, rp;
  logic [CW-1:0]     count;
  logic              busy;
  req_t              cur;
  logic [1:0]        tag_st [LINES];
  logic [NODE_W-1:0] tag_hd [LINES];

  wire push = req_valid && req_ready;
  wire pop  = !busy && (count != '0);
  assign req_ready = (count != CW'(QDEPTH));

  function automatic logic [QW-1:0] bump(input logic [QW-1:0] p);
    return (p == QW'(QDEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk)
    if (push) q_mem[wp] <= '{wr: req_wr, node: req_node, line: req_line};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= bump(wp);
      if (pop)  rp <= bump(rp);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  logic [1:0] raw_st, eff_st, nxt_st;
  logic       has_list;
  assign raw_st   = tag_st[cur.line];
  assign eff_st   = (raw_st == ST_FRESH || raw_st == ST_GONE) ? raw_st : ST_HOME;
  assign has_list = (eff_st != ST_HOME);
  assign nxt_st   = (eff_st == ST_GONE || cur.wr) ? ST_GONE : ST_FRESH;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy         <= 1'b0;
      cur          <= '0;
      rsp_valid    <= 1'b0;
      rsp_node     <= '0;
      rsp_line     <= '0;
      rsp_data     <= 1'b0;
      rsp_head_vld <= 1'b0;
      rsp_head     <= '0;
      rsp_state    <= ST_HOME;
      for (int i = 0; i < LINES; i++) begin
        tag_st[i] <= ST_HOME;
        tag_hd[i] <= '0;
      end
    end else begin
      rsp_valid <= 1'b0;
      if (pop) begin
        cur  <= q_mem[rp];
        busy <= 1'b1;
      end else if (busy) begin
        busy             <= 1'b0;
        rsp_valid        <= 1'b1;
        rsp_node         <= cur.node;
        rsp_line         <= cur.line;
        rsp_data         <= (eff_st != ST_GONE);
        rsp_head_vld     <= has_list;
        rsp_head         <= has_list ? tag_hd[cur.line] : '0;
        rsp_state        <= nxt_st;
        tag_st[cur.line] <= nxt_st;
        tag_hd[cur.line] <= cur.node;
      end
    end
  end
endmodule

// File: rtl/coh_home_dir_chk.sv
module coh_home_dir_chk #(
  parameter int QDEPTH = 4,
  parameter int CW     = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rsp_valid,
  input logic          rsp_data,
  input logic          rsp_head_vld,
  input logic [1:0]    rsp_state,
  input logic          cur_wr,
  input logic          busy,
  input logic [CW-1:0] count
);
  AST_RSP_SPACED: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |=> !rsp_valid); // R9
  AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n) busy |-> !rsp_valid); // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) count <= CW'(QDEPTH)); // R8
  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |-> (rsp_state == 2'b01 || rsp_state == 2'b10)); // R2
  AST_WR_DIRTY: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && cur_wr) |-> rsp_state == 2'b10); // R4
  AST_NODATA_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && !rsp_data) |-> (rsp_head_vld && rsp_state == 2'b10)); // R6
  AST_DATA_OR_HEAD: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |-> (rsp_data || rsp_head_vld)); // R5
endmodule

bind coh_home_dir coh_home_dir_chk #(.QDEPTH(QDEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
  .rsp_head_vld(rsp_head_vld), .rsp_state(rsp_state), .cur_wr(cur.wr),
  .busy(busy), .count(count)
);

// File: tb/test_coh_home_dir.sv
`timescale 1ns/1ps
module test_coh_home_dir;
  localparam int NODE_W = 4;
  localparam int LINE_W = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_wr = 1'b0;
  logic [NODE_W-1:0] req_node = '0;
  logic [LINE_W-1:0] req_line = '0;
  logic req_ready, rsp_valid, rsp_data, rsp_head_vld;
  logic [NODE_W-1:0] rsp_node, rsp_head;
  logic [LINE_W-1:0] rsp_line;
  logic [1:0] rsp_state;

  int n_chk = 0, n_fail = 0, cyc = 0, n_log = 0;
  int log_node [64];
  int log_head [64];
  int log_cyc  [64];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  coh_home_dir #(.NODE_W(NODE_W), .LINE_W(LINE_W), .QDEPTH(4)) i_coh_home_dir (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_wr(req_wr), .req_node(req_node), .req_line(req_line),
    .rsp_valid(rsp_valid), .rsp_node(rsp_node), .rsp_line(rsp_line),
    .rsp_data(rsp_data), .rsp_head_vld(rsp_head_vld), .rsp_head(rsp_head),
    .rsp_state(rsp_state)
  );

  always @(negedge clk)
    if (rst_n && rsp_valid && n_log < 64) begin
      log_node[n_log] = int'(rsp_node);
      log_head[n_log] = rsp_head_vld ? int'(rsp_head) : -1;
      log_cyc[n_log]  = cyc;
      n_log++;
    end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push_req(input logic wr, input int node, input int line);
    req_wr = wr; req_node = NODE_W'(node); req_line = LINE_W'(line); req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R1", "ready after reset", int'(req_ready), 1);
    check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", int'(rsp_valid), 0);
  endtask

  task automatic t_fetch(input logic wr, input int node, input int line, input int e_data,
                         input int e_hv, input int e_head, input int e_st, input string req);
    push_req(wr, node, line);
    @(negedge clk);
    check(rsp_valid == 1'b0, "R9", "early answer", int'(rsp_valid), 0);
    @(negedge clk);
    check(rsp_valid == 1'b1, "R9", "answer two cycles after accept", int'(rsp_valid), 1);
    check(int'(rsp_node) == node, req, "rsp_node", int'(rsp_node), node);
    check(int'(rsp_line) == line, req, "rsp_line", int'(rsp_line), line);
    check(int'(rsp_data) == e_data, req, "rsp_data", int'(rsp_data), e_data);
    check(int'(rsp_head_vld) == e_hv, req, "rsp_head_vld", int'(rsp_head_vld), e_hv);
    if (e_hv != 0) check(int'(rsp_head) == e_head, req, "rsp_head", int'(rsp_head), e_head);
    check(int'(rsp_state) == e_st, req, "rsp_state", int'(rsp_state), e_st);
    @(negedge clk);
  endtask

  task automatic t_line_sequence;
    t_fetch(1'b0, 3, 0, 1, 0, 0, 1, "R3");
    t_fetch(1'b0, 5, 0, 1, 1, 3, 1, "R10");
    t_fetch(1'b1, 7, 0, 1, 1, 5, 2, "R4");
    t_fetch(1'b0, 2, 0, 0, 1, 7, 2, "R6");
    t_fetch(1'b1, 9, 0, 0, 1, 2, 2, "R7");
  endtask

  task automatic t_independence;
    t_fetch(1'b1, 4, 1, 1, 0, 0, 2, "R11");
    t_fetch(1'b0, 6, 2, 1, 0, 0, 1, "R11");
    t_fetch(1'b0, 8, 2, 1, 1, 6, 1, "R5");
    t_fetch(1'b1, 1, 1, 0, 1, 4, 2, "R6");
  endtask

  task automatic t_burst;
    int base = n_log, stalls = 0, wait_c = 0;
    for (int k = 1; k <= 8; k++) begin
      req_wr = 1'b0; req_node = NODE_W'(k); req_line = 3'd5; req_valid = 1'b1;
      while (!req_ready) begin stalls++; @(negedge clk); end
      @(negedge clk);
    end
    req_valid = 1'b0;
    while (n_log - base < 8 && wait_c < 60) begin wait_c++; @(negedge clk); end
    check(stalls > 0, "R8", "ready dropped when queue full", stalls, 1);
    check(n_log - base == 8, "R8", "answers for accepted requests", n_log - base, 8);
    for (int k = 0; k < 8 && base + k < 64; k++) begin
      check(log_node[base + k] == k + 1, "R9", "arrival order node", log_node[base + k], k + 1);
      check(log_head[base + k] == (k == 0 ? -1 : k), "R7", "handed-off head", log_head[base + k], k == 0 ? -1 : k);
      if (k > 0) check(log_cyc[base + k] - log_cyc[base + k - 1] >= 2, "R9", "answer spacing",
                       log_cyc[base + k] - log_cyc[base + k - 1], 2);
    end
  endtask

  initial begin
    @(negedge clk);
    t_reset;
    t_line_sequence;
    t_independence;
    t_burst;
    t_reset;
    t_fetch(1'b0, 11, 0, 1, 0, 0, 1, "R1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule